// File: doc/BRIEF.md
# Multiport Registered Memory Array

This block is a synchronous storage array of 64 words, each 72 bits wide, built from flip-flops. It offers several independent read ports and write ports that all work in the same clock cycle. Every port first captures its request (enable, address and, for a write, the data word) into a register on the rising clock edge. The array acts on the captured request one edge later. A read therefore returns its word two cycles after it is presented. A write can be read back by a request issued on the very next cycle.

A single elaboration-time switch selects the port count. The narrow build has two read ports and one write port. The wide build has four read ports and two write ports. When two write ports hit the same word in the same cycle, the higher-numbered port takes the word. Reset is synchronous and active high. It clears only the per-port request and output registers, so stored words survive it. A read and a write to the same word in the same cycle give an undefined read result, and users must avoid that case.

Top module: `mpa_array`

## Requirements
- R1: The array stores 64 words of 72 bits, selected by a 6-bit word address on each port. A word written to an address is returned unchanged by a later read of that address.
- R2: With `WIDE`=0 there are two read ports and one write port. With `WIDE`=1 there are four read ports and two write ports. All ports operate independently in the same cycle, and bit i of each packed port vector belongs to port i.
- R3: A read request presented with its enable high in cycle N shows its word on that port's data output in cycle N+2. In cycle N+1 the output still shows the result of the earlier request.
- R4: A write presented in cycle N is seen by a read presented in cycle N+1 or any later cycle.
- R5: If both write ports are enabled with the same address in one cycle, the word stored is the data of write port 1.
- R6: A write port whose enable is low leaves every stored word unchanged, whatever its address and data inputs hold.
- R7: A read port whose enable is low keeps its data output at the previous value.
- R8: While `rst` is high at a rising edge, all read data outputs become zero and all captured enables become zero. A write presented during reset is not performed, and stored words are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the port registers |
| rd_en | input | NRD | Per read port request enable |
| rd_addr | input | NRD*6 | Per read port word address |
| rd_data | output | NRD*72 | Per read port returned word, two cycles after the request |
| wr_en | input | NWR | Per write port request enable |
| wr_addr | input | NWR*6 | Per write port word address |
| wr_data | input | NWR*72 | Per write port data word |

## Verification
Inputs change and outputs are sampled on the falling clock edge. A read presented at one falling edge is therefore compared two falling edges later, and the output one falling edge after the request is checked against the older value. A write is modelled as visible at once, and its read-back is issued on the falling edge that follows it. That read-back is captured one edge after the array update, which lands one edge after the write is captured. No check ever issues a read and a write to the same word in one cycle. The pipelined test issues a new read every cycle and checks each word exactly two cycles after it was requested.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
    localparam int MPA_DEPTH = 64;
    localparam int MPA_WIDTH = 72;
    localparam int MPA_AW    = $clog2(MPA_DEPTH);

    typedef logic [MPA_AW-1:0]    addr_t;
    typedef logic [MPA_WIDTH-1:0] word_t;
    typedef logic [MPA_DEPTH-1:0][MPA_WIDTH-1:0] array_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
    } rd_req_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_req_t;

    function automatic int rd_ports(bit wide);
        return wide ? 4 : 2;
    endfunction

    function automatic int wr_ports(bit wide);
        return wide ? 2 : 1;
    endfunction
endpackage

// File: rtl/mpa_wr_capture.sv
module mpa_wr_capture import mpa_pkg::*; #(
    parameter int NWR = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NWR-1:0]                 wr_en,
    input  logic [NWR-1:0][MPA_AW-1:0]     wr_addr,
    input  logic [NWR-1:0][MPA_WIDTH-1:0]  wr_data,
    output wr_req_t [NWR-1:0]              req_q
);
    for (genvar k = 0; k < NWR; k++) begin : g_wr
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[k] <= '0;
            end else begin
                req_q[k].en   <= wr_en[k];
                req_q[k].addr <= wr_addr[k];
                req_q[k].data <= wr_data[k];
            end
        end

        AST_WR_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !req_q[k].en); // R8
    end
endmodule

// File: rtl/mpa_storage.sv
module mpa_storage import mpa_pkg::*; #(
    parameter int NWR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t [NWR-1:0] req,
    output array_t            mem
);
    // Ascending loop: a later port overrides an earlier one on the same word.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NWR; k++) begin
            if (req[k].en) begin
                mem[req[k].addr] <= req[k].data;
            end
        end
    end

    AST_WR_TOP_PORT_LANDS: assert property (@(posedge clk) disable iff (rst)
        req[NWR-1].en |=> mem[$past(req[NWR-1].addr)] == $past(req[NWR-1].data)); // R5

    for (genvar k = 0; k < NWR-1; k++) begin : g_low
        logic shadowed;
        always_comb begin
            shadowed = 1'b0;
            for (int j = k + 1; j < NWR; j++) begin
                if (req[j].en && (req[j].addr == req[k].addr)) shadowed = 1'b1;
            end
        end

        AST_WR_LOW_PORT_LANDS: assert property (@(posedge clk) disable iff (rst)
            (req[k].en && !shadowed) |=> mem[$past(req[k].addr)] == $past(req[k].data)); // R4
    end
endmodule

// File: rtl/mpa_rd_port.sv
module mpa_rd_port import mpa_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_en,
    input  addr_t  rd_addr,
    input  array_t mem,
    output word_t  rd_data
);
    rd_req_t req_q;
    word_t   data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.en   <= rd_en;
            req_q.addr <= rd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (req_q.en) begin
            data_q <= mem[req_q.addr];
        end
    end

    assign rd_data = data_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_q.en |=> $stable(data_q)); // R7

    AST_RD_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (data_q == '0 && !req_q.en)); // R8
endmodule

// File: rtl/mpa_array.sv
module mpa_array import mpa_pkg::*; #(
    parameter  bit WIDE = 1'b0,
    localparam int NRD  = rd_ports(WIDE),
    localparam int NWR  = wr_ports(WIDE)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NRD-1:0]                rd_en,
    input  logic [NRD-1:0][MPA_AW-1:0]    rd_addr,
    output logic [NRD-1:0][MPA_WIDTH-1:0] rd_data,
    input  logic [NWR-1:0]                wr_en,
    input  logic [NWR-1:0][MPA_AW-1:0]    wr_addr,
    input  logic [NWR-1:0][MPA_WIDTH-1:0] wr_data
);
    wr_req_t [NWR-1:0] wr_q;
    array_t            mem;

    mpa_wr_capture #(.NWR(NWR)) u_wcap (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req_q   (wr_q)
    );

    mpa_storage #(.NWR(NWR)) u_store (
        .clk (clk),
        .rst (rst),
        .req (wr_q),
        .mem (mem)
    );

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        mpa_rd_port u_rd (
            .clk     (clk),
            .rst     (rst),
            .rd_en   (rd_en[i]),
            .rd_addr (rd_addr[i]),
            .mem     (mem),
            .rd_data (rd_data[i])
        );
    end

    AST_RST_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == '0)); // R8
endmodule

// File: tb/tb_mpa_array.sv
`timescale 1ns/1ps
module tb_mpa_array;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [3:0]        rd_en;
    logic [3:0][5:0]   rd_addr;
    logic [3:0][71:0]  rd_data;
    logic [1:0]        wr_en;
    logic [1:0][5:0]   wr_addr;
    logic [1:0][71:0]  wr_data;

    logic [1:0]        n_rd_en;
    logic [1:0][5:0]   n_rd_addr;
    logic [1:0][71:0]  n_rd_data;
    logic [0:0]        n_wr_en;
    logic [0:0][5:0]   n_wr_addr;
    logic [0:0][71:0]  n_wr_data;

    mpa_array #(.WIDE(1'b1)) dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    mpa_array dut_n (
        .clk(clk), .rst(rst), .rd_en(n_rd_en), .rd_addr(n_rd_addr), .rd_data(n_rd_data),
        .wr_en(n_wr_en), .wr_addr(n_wr_addr), .wr_data(n_wr_data)
    );

    logic [71:0] model [64];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [71:0] pat(int a, logic [63:0] salt);
        return {8'(a), (64'(a) * 64'h9E37_79B9_7F4A_7C15) ^ salt};
    endfunction

    task automatic check(string req, logic [71:0] act, logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = '0; rd_addr = '0; wr_en = '0; wr_addr = '0; wr_data = '0;
        n_rd_en = '0; n_rd_addr = '0; n_wr_en = '0; n_wr_addr = '0; n_wr_data = '0;
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic write1(int p, int a, logic [71:0] d);
        wr_en[p] = 1'b1; wr_addr[p] = 6'(a); wr_data[p] = d;
        @(negedge clk);
        wr_en[p] = 1'b0;
        model[a] = d;
    endtask

    task automatic read1(int p, int a, output logic [71:0] v);
        rd_en[p] = 1'b1; rd_addr[p] = 6'(a);
        @(negedge clk);
        rd_en[p] = 1'b0;
        @(negedge clk);
        v = rd_data[p];
    endtask

    task automatic t_reset();
        for (int p = 0; p < 4; p++) check("R8 reset output zero", rd_data[p], '0);
    endtask

    task automatic t_fill_and_read_all();
        for (int a = 0; a < 64; a++) write1(a % 2, a, pat(a, 64'h5A5A_0000_1234_0000));
        for (int a = 0; a < 64; a += 4) begin
            for (int p = 0; p < 4; p++) begin rd_en[p] = 1'b1; rd_addr[p] = 6'(a + p); end
            @(negedge clk);
            rd_en = '0;
            @(negedge clk);
            for (int p = 0; p < 4; p++) check("R1 R2 parallel read", rd_data[p], model[a + p]);
        end
    endtask

    task automatic t_latency();
        logic [71:0] prev;
        logic [71:0] v;
        read1(0, 3, prev);
        rd_en[0] = 1'b1; rd_addr[0] = 6'd9;
        @(negedge clk);
        rd_en[0] = 1'b0;
        check("R3 not yet at N+1", rd_data[0], prev);
        @(negedge clk);
        check("R3 valid at N+2", rd_data[0], model[9]);
        v = rd_data[0];
    endtask

    task automatic t_write_then_read();
        logic [71:0] v;
        wr_en[0] = 1'b1; wr_addr[0] = 6'd10; wr_data[0] = pat(10, 64'hFEED_0000_0000_BEEF);
        @(negedge clk);
        wr_en[0] = 1'b0;
        model[10] = pat(10, 64'hFEED_0000_0000_BEEF);
        read1(2, 10, v);
        check("R4 next-cycle read sees write", v, model[10]);
    endtask

    task automatic t_pipelined();
        for (int i = 0; i < 10; i++) begin
            if (i >= 2) check("R3 pipelined read", rd_data[1], model[20 + i - 2]);
            rd_en[1] = (i < 8); rd_addr[1] = 6'(20 + i);
            @(negedge clk);
        end
        rd_en[1] = 1'b0;
    endtask

    task automatic t_priority();
        logic [71:0] v;
        wr_en = 2'b11; wr_addr[0] = 6'd30; wr_addr[1] = 6'd30;
        wr_data[0] = pat(30, 64'h0000_0000_0000_0001);
        wr_data[1] = pat(30, 64'h0000_0000_0000_0002);
        @(negedge clk);
        model[30] = pat(30, 64'h0000_0000_0000_0002);
        wr_addr[0] = 6'd31; wr_addr[1] = 6'd32;
        wr_data[0] = pat(31, 64'h3); wr_data[1] = pat(32, 64'h4);
        @(negedge clk);
        wr_en = '0;
        model[31] = pat(31, 64'h3); model[32] = pat(32, 64'h4);
        read1(3, 30, v); check("R5 write port 1 wins", v, model[30]);
        read1(0, 31, v); check("R2 write port 0 lands", v, model[31]);
        read1(1, 32, v); check("R2 write port 1 lands", v, model[32]);
    endtask

    task automatic t_write_disabled();
        logic [71:0] v;
        wr_en = '0; wr_addr[0] = 6'd40; wr_addr[1] = 6'd41;
        wr_data[0] = '1; wr_data[1] = '1;
        @(negedge clk);
        @(negedge clk);
        read1(0, 40, v); check("R6 disabled port 0 no write", v, model[40]);
        read1(1, 41, v); check("R6 disabled port 1 no write", v, model[41]);
    endtask

    task automatic t_read_hold();
        logic [71:0] v;
        read1(3, 12, v);
        check("R7 setup read", v, model[12]);
        rd_en[3] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rd_addr[3] = 6'(50 + i);
            @(negedge clk);
            check("R7 disabled read holds", rd_data[3], model[12]);
        end
    endtask

    task automatic t_reset_mid();
        logic [71:0] v;
        rst = 1'b1;
        wr_en[0] = 1'b1; wr_addr[0] = 6'd50; wr_data[0] = '1;
        @(negedge clk);
        wr_en[0] = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < 4; p++) check("R8 outputs zero after reset", rd_data[p], '0);
        @(negedge clk);
        read1(0, 50, v); check("R8 write during reset dropped", v, model[50]);
        read1(1, 5, v);  check("R8 contents kept over reset", v, model[5]);
    endtask

    task automatic t_narrow();
        logic [71:0] d;
        d = pat(7, 64'hC0DE_C0DE_0000_0007);
        n_wr_en[0] = 1'b1; n_wr_addr[0] = 6'd7; n_wr_data[0] = d;
        @(negedge clk);
        n_wr_en[0] = 1'b0;
        n_rd_en = 2'b11; n_rd_addr[0] = 6'd7; n_rd_addr[1] = 6'd7;
        @(negedge clk);
        n_rd_en = '0;
        @(negedge clk);
        check("R2 narrow read port 0", n_rd_data[0], d);
        check("R2 narrow read port 1", n_rd_data[1], d);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_and_read_all();
        t_latency();
        t_write_then_read();
        t_pipelined();
        t_priority();
        t_write_disabled();
        t_read_hold();
        t_reset_mid();
        t_narrow();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule